// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent 32-bit down-counters behind a plain register bus: an address, a write strobe, write data and combinational read data. One shared control word holds a run bit and a reload bit for each counter. Each counter also has a reload register, and its live count can be both read and written. When a count tick arrives and the counter is enabled, it drops by one. When it reaches zero it expires. It then either reloads from its reload register, which gives a periodic event, or stays at zero as a one-shot. Each expiry drives a one-cycle interrupt pulse on that counter's own output.

Software can use one counter as a free-running time base. It loads all ones into both the reload and count registers, sets reload, and reads the inverted count to get a rising value. The other counter then serves as a one-shot or periodic event source. To get a period of N ticks, software programs N-1 into the reload and count registers. Ticks come from an external enable input, so the clock divider is outside this block.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, the control word, both counts and both reload registers read zero, and both interrupt outputs are low.
- R2: Register offsets are: control at 0x00, counter 0 reload at 0x10, counter 0 count at 0x14, counter 1 reload at 0x18, counter 1 count at 0x1C. Control bits: bit 0 runs counter 0, bit 1 selects reload for counter 0, bit 2 runs counter 1, bit 3 selects reload for counter 1. Control bits above 3 read zero. Any unmapped offset reads zero.
- R3: While its run bit is set, a counter decrements by exactly one on each cycle with tick_i high. It does not change on cycles without a tick.
- R4: While its run bit is clear, a counter holds its value whatever tick_i does.
- R5: When a running counter with its reload bit set sees a tick while at zero, it loads its reload value. Programming N-1 therefore gives one expiry every N ticks.
- R6: With its reload bit clear, a counter that expires stays at zero and raises only one pulse. Later ticks do not pulse again until the count is rewritten.
- R7: An expiry drives that counter's interrupt output high for exactly the one cycle after the expiring tick. The outputs are irq_o[0] for counter 0 and irq_o[1] for counter 1.
- R8: A bus write to a count register takes priority over a decrement or reload in the same cycle. That cycle raises no interrupt.
- R9: With all ones loaded into both the reload and count registers and reload set, a counter wraps from zero to 0xFFFFFFFF and keeps counting down.
- R10: The two counters run independently. A tick that reloads one counter leaves a stopped counter's value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable tick |
| bus_addr | input | 6 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 2 | One-cycle expiry pulse per counter |

## Verification
Two events can fall in the same cycle: a bus write to a count register, and a tick that would decrement or reload that counter. The bench drives a count write and tick_i high in the same cycle twice: once on a counter partway through counting, and once on a reloading counter sitting at zero. It then reads the count back and checks that it holds the written value with no interrupt pulse. A second overlap, an expiry on one counter while the other is stopped, is judged by reading both counts and the interrupt vector right after the tick.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 6;
    localparam int N_TMR  = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             irq;
        logic             fired;
    } chan_state_t;
endpackage

// File: rtl/dct_channel.sv
module dct_channel
    import dct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             auto_i,
    input  logic             rld_we_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             irq_o
);
    chan_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (rld_we_i) begin
            st_d.rld = wdata_i;
        end
        if (cnt_we_i) begin
            st_d.cnt   = wdata_i;
            st_d.fired = 1'b0;
        end else if (run_i && tick_i) begin
            if (st_q.cnt == '0) begin
                if (auto_i) begin
                    st_d.cnt = st_q.rld;
                    st_d.irq = 1'b1;
                end else if (!st_q.fired) begin
                    st_d.irq   = 1'b1;
                    st_d.fired = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign rld_o = st_q.rld;
    assign irq_o = st_q.irq;
endmodule

// File: rtl/dct_readmux.sv
module dct_readmux
    import dct_pkg::*;
(
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [2*N_TMR-1:0]          ctrl_i,
    input  logic [N_TMR-1:0][CNT_W-1:0] cnt_i,
    input  logic [N_TMR-1:0][CNT_W-1:0] rld_i,
    output logic [CNT_W-1:0]            rdata_o
);
    localparam int CTRL_W = 2 * N_TMR;

    always_comb begin
        rdata_o = '0;
        if (addr_i == '0) begin
            rdata_o[CTRL_W-1:0] = ctrl_i;
        end
        for (int i = 0; i < N_TMR; i++) begin
            if (addr_i == ADDR_W'(16 + 8 * i)) rdata_o = rld_i[i];
            if (addr_i == ADDR_W'(20 + 8 * i)) rdata_o = cnt_i[i];
        end
    end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import dct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_TMR-1:0]  irq_o
);
    localparam int CTRL_W = 2 * N_TMR;

    logic [CTRL_W-1:0]           ctrl_d, ctrl_q;
    logic [N_TMR-1:0][CNT_W-1:0] cnt_all;
    logic [N_TMR-1:0][CNT_W-1:0] rld_all;

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we && bus_addr == '0) begin
            ctrl_d = bus_wdata[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_chan
        logic rld_we, cnt_we;
        assign rld_we = bus_we && (bus_addr == ADDR_W'(16 + 8 * g));
        assign cnt_we = bus_we && (bus_addr == ADDR_W'(20 + 8 * g));

        dct_channel u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .run_i    (ctrl_q[2*g]),
            .auto_i   (ctrl_q[2*g+1]),
            .rld_we_i (rld_we),
            .cnt_we_i (cnt_we),
            .wdata_i  (bus_wdata),
            .cnt_o    (cnt_all[g]),
            .rld_o    (rld_all[g]),
            .irq_o    (irq_o[g])
        );
    end

    dct_readmux u_rmux (
        .addr_i  (bus_addr),
        .ctrl_i  (ctrl_q),
        .cnt_i   (cnt_all),
        .rld_i   (rld_all),
        .rdata_o (bus_rdata)
    );
endmodule

// File: rtl/dct_checker.sv
module dct_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        we,
    input logic [5:0]  addr,
    input logic [31:0] wdata,
    input logic [3:0]  ctrl,
    input logic [31:0] cnt0,
    input logic [31:0] cnt1,
    input logic [1:0]  irq
);
    logic wr0, wr1;
    assign wr0 = we && addr == 6'h14;
    assign wr1 = we && addr == 6'h1C;

    // R8
    write_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> cnt0 == $past(wdata));

    // R4
    frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[2] && !wr1) |=> $stable(cnt1));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && tick && cnt0 != 32'd0 && !wr0) |=> cnt0 == $past(cnt0) - 32'd1);

    // R6
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !ctrl[1] && cnt0 == 32'd0 && !wr0) |=> cnt0 == 32'd0);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> $past(ctrl[0] && tick && cnt0 == 32'd0 && !wr0));

    // R7
    irq1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> $past(ctrl[2] && tick && cnt1 == 32'd0 && !wr1));
endmodule

bind dual_countdown_timer dct_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_i),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .ctrl  (ctrl_q),
    .cnt0  (cnt_all[0]),
    .cnt1  (cnt_all[1]),
    .irq   (irq_o)
);

// File: tb/dual_countdown_timer_test.sv
module dual_countdown_timer_test;
    localparam time HALF = 2ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sbq[$];

    always #HALF clk = ~clk;

    dual_countdown_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // monitor: compares queued items shortly after the driver set them up
    always begin
        @(negedge clk);
        #1ns;
        while (sbq.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            act = it.is_irq ? {30'd0, irq_o} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: %s actual %h expected %h", it.req,
                         it.is_irq ? "irq" : "rdata", act, it.exp);
            end
        end
    end

    task automatic op(input bit we, input logic [5:0] a, input logic [31:0] d, input bit t);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; tick_i = t;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] e,
                             input logic [1:0] ei, input string req);
        sb_item_t it;
        @(negedge clk);
        bus_we = 1'b0; tick_i = 1'b0; bus_addr = a;
        it.is_irq = 0; it.exp = e; it.req = req; sbq.push_back(it);
        it.is_irq = 1; it.exp = {30'd0, ei}; sbq.push_back(it);
    endtask

    initial begin
        #(HALF * 2 * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(6'h00, 0, 2'b00, "R1");
        expect_rd(6'h10, 0, 2'b00, "R1");
        expect_rd(6'h14, 0, 2'b00, "R1");
        expect_rd(6'h18, 0, 2'b00, "R1");
        expect_rd(6'h1C, 0, 2'b00, "R1");
        // R2 map and readback
        op(1, 6'h00, 32'hFA, 0);
        expect_rd(6'h00, 32'hA, 2'b00, "R2");
        op(1, 6'h00, 32'h0, 0);
        op(1, 6'h10, 32'h1234, 0);
        op(1, 6'h18, 32'hBEEF, 0);
        op(1, 6'h1C, 32'h55, 0);
        expect_rd(6'h10, 32'h1234, 2'b00, "R2");
        expect_rd(6'h18, 32'hBEEF, 2'b00, "R2");
        expect_rd(6'h1C, 32'h55, 2'b00, "R2");
        expect_rd(6'h04, 32'h0, 2'b00, "R2");
        // R3 decrement per tick
        op(1, 6'h14, 32'd10, 0);
        op(1, 6'h00, 32'h1, 0);
        for (int i = 0; i < 3; i++) op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd7, 2'b00, "R3");
        op(0, 6'h00, 0, 0);
        expect_rd(6'h14, 32'd7, 2'b00, "R3");
        // R4 stopped counter frozen
        op(1, 6'h00, 32'h0, 0);
        op(0, 6'h00, 0, 1);
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd7, 2'b00, "R4");
        // R5 periodic reload, period 3 ticks; R7 pulse width
        op(1, 6'h10, 32'd2, 0);
        op(1, 6'h14, 32'd0, 0);
        op(1, 6'h00, 32'h3, 0);
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd2, 2'b01, "R5");
        expect_rd(6'h14, 32'd2, 2'b00, "R7");
        op(0, 6'h00, 0, 1);
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd0, 2'b00, "R5");
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd2, 2'b01, "R5");
        // R6 one-shot
        op(1, 6'h14, 32'd1, 0);
        op(1, 6'h00, 32'h1, 0);
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd0, 2'b00, "R6");
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd0, 2'b01, "R6");
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'd0, 2'b00, "R6");
        // R8 write beats decrement and reload
        op(1, 6'h14, 32'd5, 0);
        op(1, 6'h14, 32'd9, 1);
        expect_rd(6'h14, 32'd9, 2'b00, "R8");
        op(1, 6'h00, 32'h3, 0);
        op(1, 6'h14, 32'd0, 0);
        op(1, 6'h14, 32'd7, 1);
        expect_rd(6'h14, 32'd7, 2'b00, "R8");
        // R9 full-range wrap
        op(1, 6'h10, 32'hFFFF_FFFF, 0);
        op(1, 6'h14, 32'd0, 0);
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'hFFFF_FFFF, 2'b01, "R9");
        op(0, 6'h00, 0, 1);
        expect_rd(6'h14, 32'hFFFF_FFFE, 2'b00, "R9");
        // R10 independence
        op(1, 6'h00, 32'h0, 0);
        op(1, 6'h14, 32'd50, 0);
        op(1, 6'h18, 32'd1, 0);
        op(1, 6'h1C, 32'd0, 0);
        op(1, 6'h00, 32'hC, 0);
        op(0, 6'h00, 0, 1);
        expect_rd(6'h1C, 32'd1, 2'b10, "R10");
        expect_rd(6'h14, 32'd50, 2'b00, "R10");
        op(0, 6'h00, 0, 1);
        op(0, 6'h00, 0, 1);
        expect_rd(6'h1C, 32'd1, 2'b10, "R10");
        op(0, 6'h00, 0, 0);
        op(0, 6'h00, 0, 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule